// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Boot Detection

This block is a system-management watchdog. A down-counter runs from a programmable timeout value and moves one step on each tick pulse. Software stops it from expiring by writing to a kick register, which restarts the count. Software can also read the live count to see how much time is left.

Expiry is handled in two stages. The first expiry raises a one-cycle interrupt, sets a first-stage status flag and restarts the count on its own. If that flag is still set when the next expiry arrives, the block sets a second-stage flag. It then either raises a held reset request or, when the no-reboot control bit is set, only records the event.

A separate status flag reports a processor that never fetched its first instruction. It is set when an expiry arrives and no fetch has been seen since power-on reset or since the last watchdog reset. Every status flag survives the watchdog's own reset, so firmware can see afterwards why the reboot happened.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset the count and the timeout register both hold RESET_LOAD. The status (address 2) and control (address 3) registers read 0, and irq and rst_req are low.
- R2: Each tick pulse lowers the count by one when it is above zero. The count reads back at address 1.
- R3: Any write to address 1 loads the count from the timeout register. In the same cycle this write takes priority over a tick.
- R4: A tick while the count is 0 is an expiry: the count reloads from the timeout register. If status bit 0 is clear, that bit is set and irq is high for exactly one cycle.
- R5: An expiry while status bit 0 is set sets status bit 1 and raises no interrupt.
- R6: On a second-stage expiry with control bit 0 (no-reboot) clear, rst_req goes high and stays high until rst_done. With that bit set, rst_req stays low but status bit 1 is still set.
- R7: Status bits are write-1-to-clear, and zero bits in the written data have no effect. Once bit 0 is cleared, the next expiry is handled as a first stage again.
- R8: An expiry with no fetch_seen pulse since power-on reset or since the last rst_done acknowledge sets status bit 2. After a fetch has been seen, an expiry leaves bit 2 clear.
- R9: rst_done while rst_req is high drops rst_req, reloads the count and re-arms fetch detection. The status, timeout and control registers are kept.
- R10: A write to address 0 changes the timeout value but leaves the running count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_addr | input | 2 | Register address: 0 timeout, 1 count/kick, 2 status, 3 control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| tick | input | 1 | Count-enable pulse |
| fetch_seen | input | 1 | Pulse marking the processor's first instruction fetch |
| rst_done | input | 1 | Acknowledge that the requested reset has completed |
| irq | output | 1 | One-cycle management interrupt on a first-stage expiry |
| rst_req | output | 1 | System reset request, held until rst_done |

## Verification
The bench builds the block with CNT_W = 8 and RESET_LOAD = 3. It then writes timeout values of 1 and 5, so every expiry arrives within a few ticks. This keeps both escalation stages, the auto-reload after an expiry, the held reset request and the missing-fetch flag within a few dozen cycles of each other. At that scale one run also covers kick-versus-tick priority and the write-1-to-clear re-arming path.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      A_TIMEOUT = 2'd0,
      A_COUNT   = 2'd1,
      A_STATUS  = 2'd2,
      A_CONTROL = 2'd3
   } wdt_addr_e;

   localparam int STS_W      = 3;
   localparam int STS_FIRST  = 0;
   localparam int STS_SECOND = 1;
   localparam int STS_NOCPU  = 2;
   localparam int CTL_NOBOOT = 0;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W      = 16,
   parameter int RESET_LOAD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] INIT = CNT_W'(RESET_LOAD);

   assign expire = tick && !reload && (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= INIT;
      else if (reload)  count <= load_val;
      else if (expire)  count <= load_val;
      else if (tick)    count <= count - 1'b1;
   end

   // R2
   cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !reload && count != '0 |=> count == CNT_W'($past(count) - 1'b1));
   // R3
   cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> count == $past(load_val));
   // R4
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> count == $past(load_val));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int RESET_LOAD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wr,
   input  logic [CNT_W-1:0] reg_wdata,
   input  logic [CNT_W-1:0] count,
   input  logic [STS_W-1:0] status,
   output logic [CNT_W-1:0] load_val,
   output logic             no_reboot,
   output logic             kick,
   output logic [STS_W-1:0] sts_clr,
   output logic [CNT_W-1:0] reg_rdata
);
   localparam logic [CNT_W-1:0] INIT = CNT_W'(RESET_LOAD);

   wdt_addr_e addr;
   assign addr    = wdt_addr_e'(reg_addr);
   assign kick    = reg_wr && (addr == A_COUNT);
   assign sts_clr = (reg_wr && addr == A_STATUS) ? reg_wdata[STS_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_val  <= INIT;
         no_reboot <= 1'b0;
      end else if (reg_wr) begin
         if (addr == A_TIMEOUT) load_val  <= reg_wdata;
         if (addr == A_CONTROL) no_reboot <= reg_wdata[CTL_NOBOOT];
      end
   end

   always_comb begin
      unique case (addr)
         A_TIMEOUT: reg_rdata = load_val;
         A_COUNT:   reg_rdata = count;
         A_STATUS:  reg_rdata = {{(CNT_W-STS_W){1'b0}}, status};
         A_CONTROL: reg_rdata = {{(CNT_W-1){1'b0}}, no_reboot};
         default:   reg_rdata = '0;
      endcase
   end

   // R10
   load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && addr == A_TIMEOUT) |=> load_val == $past(load_val));
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
   import wdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expire,
   input  logic [STS_W-1:0] sts_clr,
   input  logic             no_reboot,
   input  logic             fetch_seen,
   input  logic             rst_done,
   output logic [STS_W-1:0] status,
   output logic             irq,
   output logic             rst_req,
   output logic             ack
);
   logic             fetch_ok;
   logic [STS_W-1:0] sts_set;
   logic             first_stage;
   logic             want_rst;

   assign ack         = rst_done && rst_req;
   assign first_stage = expire && !status[STS_FIRST];
   assign want_rst    = expire && status[STS_FIRST] && !no_reboot;

   always_comb begin
      sts_set = '0;
      sts_set[STS_FIRST]  = first_stage;
      sts_set[STS_SECOND] = expire && status[STS_FIRST];
      sts_set[STS_NOCPU]  = expire && !(fetch_ok || fetch_seen);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status   <= '0;
         irq      <= 1'b0;
         rst_req  <= 1'b0;
         fetch_ok <= 1'b0;
      end else begin
         status <= (status & ~sts_clr) | sts_set;
         irq    <= first_stage;
         if (want_rst)  rst_req <= 1'b1;
         else if (ack)  rst_req <= 1'b0;
         if (ack)             fetch_ok <= 1'b0;
         else if (fetch_seen) fetch_ok <= 1'b1;
      end
   end

   // R4
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R5
   irq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status[STS_FIRST]);
   // R6
   rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req && !rst_done |=> rst_req);
   // R6
   rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> !$past(no_reboot) && status[STS_SECOND]);
   // R9
   sts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack && status[STS_SECOND] && !sts_clr[STS_SECOND] |=> status[STS_SECOND]);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
   import wdt_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int RESET_LOAD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             tick,
   input  logic             fetch_seen,
   input  logic             rst_done,
   output logic             irq,
   output logic             rst_req
);
   if (CNT_W < STS_W || CNT_W > 32) begin : g_bad_width
      $error("wdt_two_stage: CNT_W must be in 3..32");
   end
   if (RESET_LOAD < 0 || (CNT_W < 32 && RESET_LOAD >= (1 << CNT_W))) begin : g_bad_load
      $error("wdt_two_stage: RESET_LOAD does not fit CNT_W");
   end

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] load_val;
   logic [STS_W-1:0] status;
   logic [STS_W-1:0] sts_clr;
   logic             no_reboot;
   logic             kick;
   logic             expire;
   logic             ack;

   wdt_regs #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)) i_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .count(count), .status(status),
      .load_val(load_val), .no_reboot(no_reboot), .kick(kick),
      .sts_clr(sts_clr), .reg_rdata(reg_rdata)
   );

   wdt_counter #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)) i_counter (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reload(kick || ack),
      .load_val(load_val), .count(count), .expire(expire)
   );

   wdt_escalate i_escalate (
      .clk(clk), .rst_n(rst_n), .expire(expire), .sts_clr(sts_clr),
      .no_reboot(no_reboot), .fetch_seen(fetch_seen), .rst_done(rst_done),
      .status(status), .irq(irq), .rst_req(rst_req), .ack(ack)
   );
endmodule

// File: tb/test_wdt_two_stage.sv
module test_wdt_two_stage;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   typedef struct packed {
      logic         wr;
      logic [1:0]   addr;
      logic [W-1:0] data;
      logic         tk;
      logic         fe;
      logic [1:0]   ca;
      logic [W-1:0] ev;
      logic         ei;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd0, 8'd0, 1'b0, 1'b1, 2'd1, 8'd3, 1'b0},  // R1 count at RESET_LOAD
      '{1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 2'd1, 8'd2, 1'b0},  // R2
      '{1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 2'd1, 8'd1, 1'b0},  // R2
      '{1'b1, 2'd1, 8'd0, 1'b0, 1'b0, 2'd1, 8'd3, 1'b0},  // R3 kick
      '{1'b1, 2'd0, 8'd5, 1'b0, 1'b0, 2'd1, 8'd3, 1'b0},  // R10 count untouched
      '{1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 2'd0, 8'd5, 1'b0},  // R10 timeout readback
      '{1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 2'd1, 8'd2, 1'b0},  // R2
      '{1'b1, 2'd1, 8'd0, 1'b1, 1'b0, 2'd1, 8'd5, 1'b0},  // R3 kick beats tick
      '{1'b1, 2'd0, 8'd1, 1'b0, 1'b0, 2'd1, 8'd5, 1'b0},  // R10
      '{1'b1, 2'd1, 8'd0, 1'b0, 1'b0, 2'd1, 8'd1, 1'b0},  // R3
      '{1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 2'd1, 8'd0, 1'b0},  // R2 reaches 0
      '{1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 2'd2, 8'd1, 1'b1},  // R4 first expiry
      '{1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 2'd1, 8'd1, 1'b0}   // R4 auto-reload
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   reg_addr = '0;
   logic         reg_wr = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         tick = 1'b0;
   logic         fetch_seen = 1'b0;
   logic         rst_done = 1'b0;
   logic         irq;
   logic         rst_req;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_two_stage #(.CNT_W(W), .RESET_LOAD(3)) i_wdt_two_stage (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
      .fetch_seen(fetch_seen), .rst_done(rst_done), .irq(irq), .rst_req(rst_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic wr, input logic [1:0] a, input logic [W-1:0] d,
                      input logic tk, input logic fe, input logic dn);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      tick = tk; fetch_seen = fe; rst_done = dn;
      @(posedge clk);
      #1;
      reg_wr = 1'b0; tick = 1'b0; fetch_seen = 1'b0; rst_done = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input string tag, input int exp);
      reg_addr = a;
      #1;
      chk(tag, int'(reg_rdata), exp);
   endtask

   task automatic idle();
      cyc(1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 irq", int'(irq), 0);
      chk("R1 rst_req", int'(rst_req), 0);
      rst_n = 1'b1;
      #1;
      rd(2'd0, "R1 timeout", 3);
      rd(2'd2, "R1 status", 0);
      rd(2'd3, "R1 control", 0);

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].tk, VEC[i].fe, 1'b0);
         chk($sformatf("R2 R3 R4 R10 table step %0d irq", i), int'(irq), int'(VEC[i].ei));
         rd(VEC[i].ca, $sformatf("R1 R2 R3 R4 R10 table step %0d data", i), int'(VEC[i].ev));
      end

      // R5 R6 second expiry with reboot allowed
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
      chk("R5 no irq on second", int'(irq), 0);
      rd(2'd2, "R5 status", 3);
      chk("R6 rst_req raised", int'(rst_req), 1);
      for (int k = 0; k < 3; k++) begin
         idle();
         chk("R6 rst_req held", int'(rst_req), 1);
      end
      // R9 acknowledge
      cyc(1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b1);
      chk("R9 rst_req dropped", int'(rst_req), 0);
      rd(2'd2, "R9 status kept", 3);
      rd(2'd1, "R9 count reloaded", 1);
      rd(2'd0, "R9 timeout kept", 1);

      // R7 write-1-to-clear
      cyc(1'b1, 2'd2, 8'd0, 1'b0, 1'b0, 1'b0);
      rd(2'd2, "R7 zero write", 3);
      cyc(1'b1, 2'd2, 8'd2, 1'b0, 1'b0, 1'b0);
      rd(2'd2, "R7 clear bit1", 1);
      cyc(1'b1, 2'd2, 8'd1, 1'b0, 1'b0, 1'b0);
      rd(2'd2, "R7 clear bit0", 0);
      // R7 re-armed, R8 no fetch since acknowledge
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
      chk("R7 first stage again irq", int'(irq), 1);
      rd(2'd2, "R8 missing fetch flagged", 5);

      // R6 no-reboot
      cyc(1'b1, 2'd3, 8'd1, 1'b0, 1'b0, 1'b0);
      rd(2'd3, "R6 control readback", 1);
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
      rd(2'd2, "R6 status bit1 with no-reboot", 7);
      idle();
      chk("R6 no rst_req with no-reboot", int'(rst_req), 0);

      // R8 fetch seen: no missing flag
      cyc(1'b1, 2'd2, 8'd7, 1'b0, 1'b0, 1'b0);
      rd(2'd2, "R7 clear all", 0);
      cyc(1'b0, 2'd0, '0, 1'b0, 1'b1, 1'b0);
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, 2'd0, '0, 1'b1, 1'b0, 1'b0);
      chk("R8 irq", int'(irq), 1);
      rd(2'd2, "R8 fetch seen", 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule